// File: doc/BRIEF.md
# Asynchronous Static RAM Access Controller

This block sits between a synchronous host and a 32K x 8 asynchronous static RAM. The host hands over one request at a time through a valid/ready handshake. Each request carries an address, a write flag and write data. The controller then plays out the chip-select, write-enable and output-enable sequence that the memory needs, and each step is held for a whole number of clock cycles. Read data returns to the host with a single-cycle valid pulse.

The shared byte bus is split into three ports: data toward the memory, a drive enable, and data from the memory. The pad-level tri-state buffer is left to the chip top. Every analog timing limit of the memory is turned into a cycle count at elaboration time. The count is derived from the clock period and a speed-grade parameter: grade 0 is the 70 ns part, grade 1 the 85 ns part and grade 2 the 100 ns part.

The controller keeps output enable high for the whole of a write. When a write follows a read, it inserts a quiet turnaround period so that the memory releases the bus before the controller drives it.

Top module: `asram_ctrl`

## Requirements
- R1: While reset is high and after it is released, chip select, write enable and output enable are high (inactive), the bus drive enable is low, `req_ready` is high and `rd_valid` is low.
- R2: A request is taken only on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is high only when the controller is idle, so it is low in the cycle after an acceptance.
- R3: A read (`req_write` = 0) holds chip select and output enable low with write enable high for exactly RD cycles. RD is the read/address/chip-select access time or the output-enable access time, whichever is larger, converted to cycles. The bus value is captured at the edge that ends the window. `rd_valid` is high for exactly one cycle, RD cycles after the acceptance edge, and carries the byte last written to that address.
- R4: A write (`req_write` = 1) holds chip select and write enable low together for exactly WP cycles. WP is the larger of the write pulse width and the data setup time, converted to cycles. Output enable stays high and the write data is driven on every cycle of the window.
- R5: After the write window closes, the controller keeps driving the write data with chip select and write enable high for WREC cycles. WREC is the write cycle time in cycles minus WP, with a minimum of 1.
- R6: A write that follows a read does not drive the bus until at least TA cycles have passed since output enable rose. TA is the output float time converted to cycles.
- R7: The address stays stable for as long as chip select is low.
- R8: Each timing limit becomes a cycle count by dividing by the clock period and rounding up, with a minimum of one cycle. At the default 10 ns clock and grade 0 this gives RD = 7, WP = 5, WREC = 2 and TA = 3.
- R9: The controller never drives the bus while output enable is low, nor while the memory is still floating its outputs after a read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller idle, request will be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 15 | Word address |
| req_wdata | input | 8 | Write byte |
| rd_valid | output | 1 | One-cycle pulse, read byte valid |
| rd_data | output | 8 | Read byte |
| sram_addr | output | 15 | Memory address lines |
| sram_cs_n | output | 1 | Chip select, active low |
| sram_we_n | output | 1 | Write enable, active low |
| sram_oe_n | output | 1 | Output enable, active low |
| sram_dq_out | output | 8 | Byte driven toward the memory |
| sram_dq_oe | output | 1 | Drive enable for `sram_dq_out` |
| sram_dq_in | input | 8 | Byte returned by the memory |

## Verification
For a read, `rd_valid` is due exactly RD cycles after the acceptance edge (7 at the defaults). The driver stamps each expected byte with that cycle number, and the monitor compares both the data and the cycle in which it actually arrives. For writes, the memory model counts the strobe-overlap cycles (WP) and the hold cycles that follow (WREC) and compares each count with the exact value. The turnaround is checked as a lower bound of TA undriven cycles after a read, measured at mid-cycle while the model is still floating its outputs.

// File: rtl/asram_pkg.sv
package asram_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ,
        ST_TURN,
        ST_WRITE,
        ST_WREC
    } asram_state_e;

    typedef struct packed {
        logic cs_n;
        logic we_n;
        logic oe_n;
        logic drv;
    } strobe_t;

    localparam strobe_t STROBE_IDLE = '{cs_n: 1'b1, we_n: 1'b1, oe_n: 1'b1, drv: 1'b0};

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    // Round a time in ns up to whole clocks, never below one clock.
    function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned clk_ns);
        int unsigned c;
        c = (ns + clk_ns - 1) / clk_ns;
        return (c < 1) ? 1 : c;
    endfunction

    // Read/write cycle time, equal to address and chip-select access time.
    function automatic int unsigned grade_cycle_ns(input int unsigned g);
        return (g == 0) ? 70 : (g == 1) ? 85 : 100;
    endfunction

    function automatic int unsigned grade_oe_ns(input int unsigned g);
        return (g == 0) ? 35 : (g == 1) ? 45 : 50;
    endfunction

    function automatic int unsigned grade_wp_ns(input int unsigned g);
        return (g == 0) ? 45 : (g == 1) ? 55 : 60;
    endfunction

    function automatic int unsigned grade_dw_ns(input int unsigned g);
        return (g == 0) ? 30 : (g == 1) ? 35 : 40;
    endfunction

    // Worst-case time for the memory outputs to float.
    function automatic int unsigned grade_hz_ns(input int unsigned g);
        return (g == 0) ? 25 : (g == 1) ? 30 : 35;
    endfunction

endpackage

// File: rtl/asram_timer.sv
module asram_timer #(
    parameter int unsigned CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             done
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign done = (cnt_q == '0);
endmodule

// File: rtl/asram_seq.sv
module asram_seq
    import asram_pkg::*;
#(
    parameter int unsigned CNT_W    = 3,
    parameter int unsigned RD_CYC   = 7,
    parameter int unsigned TA_CYC   = 3,
    parameter int unsigned WP_CYC   = 5,
    parameter int unsigned WREC_CYC = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic             tmr_done,
    output logic             req_ready,
    output logic             accept,
    output logic             capture,
    output logic             tmr_load,
    output logic [CNT_W-1:0] tmr_val,
    output strobe_t          strobe
);
    asram_state_e state_q, state_d;
    logic         after_rd_q;

    assign req_ready = (state_q == ST_IDLE);
    assign accept    = req_valid && req_ready;
    assign capture   = (state_q == ST_READ) && tmr_done;

    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    if (!req_write)     state_d = ST_READ;
                    else if (after_rd_q) state_d = ST_TURN;
                    else                state_d = ST_WRITE;
                end
            end
            ST_READ:  if (tmr_done) state_d = ST_IDLE;
            ST_TURN:  if (tmr_done) state_d = ST_WRITE;
            ST_WRITE: if (tmr_done) state_d = ST_WREC;
            ST_WREC:  if (tmr_done) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // Each state lasts its cycle count: the timer is loaded on entry.
    assign tmr_load = (state_d != state_q);

    always_comb begin
        case (state_d)
            ST_READ:  tmr_val = CNT_W'(RD_CYC - 1);
            ST_TURN:  tmr_val = CNT_W'(TA_CYC - 1);
            ST_WRITE: tmr_val = CNT_W'(WP_CYC - 1);
            ST_WREC:  tmr_val = CNT_W'(WREC_CYC - 1);
            default:  tmr_val = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= ST_IDLE;
            after_rd_q <= 1'b0;
            strobe     <= STROBE_IDLE;
        end else begin
            state_q <= state_d;
            if (capture)
                after_rd_q <= 1'b1;
            else if (state_q == ST_TURN && tmr_done)
                after_rd_q <= 1'b0;
            // Strobes come straight from flops so the memory sees no glitches.
            strobe.cs_n <= !(state_d == ST_READ || state_d == ST_WRITE);
            strobe.we_n <= !(state_d == ST_WRITE);
            strobe.oe_n <= !(state_d == ST_READ);
            strobe.drv  <= (state_d == ST_WRITE) || (state_d == ST_WREC);
        end
    end

    // R4 and R5: a write window is always followed by its recovery phase.
    a_r5_wrec_follows_write: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_WRITE && tmr_done) |=> (state_q == ST_WREC));
endmodule

// File: rtl/asram_dpath.sv
module asram_dpath #(
    parameter int unsigned AW = 15,
    parameter int unsigned DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          accept,
    input  logic [AW-1:0] in_addr,
    input  logic [DW-1:0] in_wdata,
    input  logic          capture,
    input  logic [DW-1:0] dq_in,
    output logic [AW-1:0] addr_q,
    output logic [DW-1:0] wdata_q,
    output logic          rd_valid,
    output logic [DW-1:0] rd_data
);
    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q   <= '0;
            wdata_q  <= '0;
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= capture;
            if (accept) begin
                addr_q  <= in_addr;
                wdata_q <= in_wdata;
            end
            if (capture)
                rd_data <= dq_in;
        end
    end
endmodule

// File: rtl/asram_ctrl.sv
module asram_ctrl
    import asram_pkg::*;
#(
    parameter int unsigned ADDR_W        = 15,
    parameter int unsigned DATA_W        = 8,
    parameter int unsigned CLK_PERIOD_NS = 10,
    parameter int unsigned SPEED_GRADE   = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] sram_addr,
    output logic              sram_cs_n,
    output logic              sram_we_n,
    output logic              sram_oe_n,
    output logic [DATA_W-1:0] sram_dq_out,
    output logic              sram_dq_oe,
    input  logic [DATA_W-1:0] sram_dq_in
);
    // R8: every limit rounded up to whole clocks.
    localparam int unsigned CYC_WC   = ns_to_cyc(grade_cycle_ns(SPEED_GRADE), CLK_PERIOD_NS);
    localparam int unsigned RD_CYC   = ns_to_cyc(max2(grade_cycle_ns(SPEED_GRADE),
                                                      grade_oe_ns(SPEED_GRADE)), CLK_PERIOD_NS);
    localparam int unsigned WP_CYC   = ns_to_cyc(max2(grade_wp_ns(SPEED_GRADE),
                                                      grade_dw_ns(SPEED_GRADE)), CLK_PERIOD_NS);
    localparam int unsigned WREC_CYC = (CYC_WC > WP_CYC) ? (CYC_WC - WP_CYC) : 1;
    localparam int unsigned TA_CYC   = ns_to_cyc(grade_hz_ns(SPEED_GRADE), CLK_PERIOD_NS);
    localparam int unsigned MAX_CYC  = max2(max2(RD_CYC, WP_CYC), max2(WREC_CYC, TA_CYC));
    localparam int unsigned CNT_W    = (MAX_CYC < 2) ? 1 : $clog2(MAX_CYC);

    logic             accept, capture, tmr_load, tmr_done;
    logic [CNT_W-1:0] tmr_val;
    strobe_t          strobe;

    asram_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .done     (tmr_done)
    );

    asram_seq #(
        .CNT_W    (CNT_W),
        .RD_CYC   (RD_CYC),
        .TA_CYC   (TA_CYC),
        .WP_CYC   (WP_CYC),
        .WREC_CYC (WREC_CYC)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_write (req_write),
        .tmr_done  (tmr_done),
        .req_ready (req_ready),
        .accept    (accept),
        .capture   (capture),
        .tmr_load  (tmr_load),
        .tmr_val   (tmr_val),
        .strobe    (strobe)
    );

    asram_dpath #(.AW(ADDR_W), .DW(DATA_W)) u_dpath (
        .clk      (clk),
        .rst      (rst),
        .accept   (accept),
        .in_addr  (req_addr),
        .in_wdata (req_wdata),
        .capture  (capture),
        .dq_in    (sram_dq_in),
        .addr_q   (sram_addr),
        .wdata_q  (sram_dq_out),
        .rd_valid (rd_valid),
        .rd_data  (rd_data)
    );

    assign sram_cs_n  = strobe.cs_n;
    assign sram_we_n  = strobe.we_n;
    assign sram_oe_n  = strobe.oe_n;
    assign sram_dq_oe = strobe.drv;

    // R4: writes run with the outputs disabled and the chip selected.
    a_r4_oe_high_in_write: assert property (@(posedge clk) disable iff (rst)
        !sram_we_n |-> (sram_oe_n && !sram_cs_n && sram_dq_oe));
    // R9: never two drivers on the bus.
    a_r9_no_drive_on_read: assert property (@(posedge clk) disable iff (rst)
        !sram_oe_n |-> !sram_dq_oe);
    // R6: the cycle after a read ends stays undriven.
    a_r6_quiet_after_read: assert property (@(posedge clk) disable iff (rst)
        $rose(sram_oe_n) |=> !sram_dq_oe);
    // R3: read data strobe is a single pulse.
    a_r3_valid_pulse: assert property (@(posedge clk) disable iff (rst)
        rd_valid |=> !rd_valid);
    // R7: address held while selected.
    a_r7_addr_hold: assert property (@(posedge clk) disable iff (rst)
        (!sram_cs_n && $past(!sram_cs_n)) |-> $stable(sram_addr));
    // R2: busy right after a hand-off.
    a_r2_busy_after_accept: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready);
endmodule

// File: tb/asram_ctrl_test.sv
module asram_ctrl_test;
    localparam int GRADE  = 0;
    localparam int CLK_NS = 10;

    function automatic int cdiv(input int ns);
        int c;
        c = (ns + CLK_NS - 1) / CLK_NS;
        return (c < 1) ? 1 : c;
    endfunction

    localparam int T_CYC = (GRADE == 0) ? 70 : (GRADE == 1) ? 85 : 100;
    localparam int T_OE  = (GRADE == 0) ? 35 : (GRADE == 1) ? 45 : 50;
    localparam int T_WP  = (GRADE == 0) ? 45 : (GRADE == 1) ? 55 : 60;
    localparam int T_DW  = (GRADE == 0) ? 30 : (GRADE == 1) ? 35 : 40;
    localparam int T_HZ  = (GRADE == 0) ? 25 : (GRADE == 1) ? 30 : 35;
    // R8: expected cycle counts.
    localparam int RD   = cdiv((T_CYC > T_OE) ? T_CYC : T_OE);
    localparam int WP   = cdiv((T_WP > T_DW) ? T_WP : T_DW);
    localparam int WREC = (cdiv(T_CYC) > WP) ? cdiv(T_CYC) - WP : 1;
    localparam int TA   = cdiv(T_HZ);

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [14:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        req_ready, rd_valid;
    logic [7:0]  rd_data;
    logic [14:0] sram_addr;
    logic        sram_cs_n, sram_we_n, sram_oe_n, sram_dq_oe;
    logic [7:0]  sram_dq_out, sram_dq_in;

    always #5 clk = ~clk;

    asram_ctrl #(.CLK_PERIOD_NS(CLK_NS), .SPEED_GRADE(GRADE)) uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .rd_valid(rd_valid), .rd_data(rd_data), .sram_addr(sram_addr),
        .sram_cs_n(sram_cs_n), .sram_we_n(sram_we_n), .sram_oe_n(sram_oe_n),
        .sram_dq_out(sram_dq_out), .sram_dq_oe(sram_dq_oe), .sram_dq_in(sram_dq_in)
    );

    int unsigned cyc = 0;
    int nchk = 0, nfail = 0;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Behavioural memory model, evaluated mid-cycle.
    logic [7:0]  mem [int];
    logic [7:0]  mdata = '0;
    bit          mdrive = 0;
    int          hz_left = 0, rcnt = 0, wcnt = 0, rec = 0, gap = 0;
    bit          rd_prev = 0, wr_prev = 0, in_rec = 0, gap_on = 0;
    logic [14:0] waddr, raddr;
    logic [7:0]  wdat;
    wire rd_now = !sram_cs_n && !sram_oe_n && sram_we_n;
    wire wr_now = !sram_cs_n && !sram_we_n;
    assign sram_dq_in = mdrive ? mdata : 8'h00;

    always @(negedge clk) begin
        if (!rst) begin
            if (rd_now) begin
                mdata   = mem.exists(int'(sram_addr)) ? mem[int'(sram_addr)] : 8'h00;
                mdrive  = 1;
                hz_left = TA;
                gap_on  = 0;
                if (rd_prev) check(sram_addr == raddr, "R7", "read addr", sram_addr, raddr);
                raddr = sram_addr;
                rcnt++;
            end else if (hz_left > 0) begin
                hz_left--;
                mdrive = 1;
            end else begin
                mdrive = 0;
            end
            if (sram_dq_oe) check(!mdrive, "R9", "bus contention", 1, 0);
            if (rd_prev && !rd_now) begin
                check(rcnt == RD, "R3 R8", "read window cycles", rcnt, RD);
                rcnt = 0; gap = 0; gap_on = 1;
            end
            if (gap_on && !rd_now) begin
                if (sram_dq_oe) begin
                    check(gap >= TA, "R6", "turnaround cycles", gap, TA);
                    gap_on = 0;
                end else gap++;
            end
            if (wr_now) begin
                check(sram_oe_n && sram_dq_oe, "R4", "oe high and data driven", sram_oe_n, 1);
                if (wcnt == 0) begin
                    waddr = sram_addr; wdat = sram_dq_out;
                end else begin
                    check(sram_addr == waddr && sram_dq_out == wdat, "R7", "write addr/data stable",
                          sram_addr, waddr);
                end
                wcnt++;
            end
            if (wr_prev && !wr_now) begin
                check(wcnt == WP, "R4 R8", "write overlap cycles", wcnt, WP);
                mem[int'(waddr)] = wdat;
                wcnt = 0; in_rec = 1; rec = 0;
            end
            if (in_rec) begin
                if (sram_dq_oe) begin
                    rec++;
                    if (sram_dq_out != wdat) check(0, "R5", "hold data", sram_dq_out, wdat);
                end else begin
                    check(rec == WREC, "R5", "write hold cycles", rec, WREC);
                    in_rec = 0;
                end
            end
            rd_prev = rd_now;
            wr_prev = wr_now;
        end
    end

    // Scoreboard.
    logic [7:0]  ref_mem [int];
    logic [7:0]  exp_q [$];
    int unsigned due_q [$];

    task automatic issue(input bit w, input logic [14:0] a, input logic [7:0] d);
        @(negedge clk);
        req_valid = 1; req_write = w; req_addr = a; req_wdata = d;
        while (!req_ready) @(negedge clk);
        if (w) ref_mem[int'(a)] = d;
        else begin
            exp_q.push_back(ref_mem.exists(int'(a)) ? ref_mem[int'(a)] : 8'h00);
            due_q.push_back(cyc + 1 + RD);
        end
        @(negedge clk);
        req_valid = 0;
        check(!req_ready, "R2", "ready after accept", req_ready, 0);
    endtask

    always @(negedge clk) begin
        if (!rst && rd_valid) begin
            if (exp_q.size() == 0) check(0, "R3", "unexpected rd_valid", 1, 0);
            else begin
                logic [7:0]  e;
                int unsigned s;
                e = exp_q.pop_front();
                s = due_q.pop_front();
                check(rd_data == e, "R3", "read data", rd_data, e);
                check(cyc == s, "R3", "read latency", cyc, s);
            end
        end
    end

    task automatic summary;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    endtask

    always @(posedge clk) begin
        if (cyc == 50000) begin
            nchk++; nfail++;
            $display("FAIL watchdog: actual %0d expected done", cyc);
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state.
        check(sram_cs_n && sram_we_n && sram_oe_n, "R1", "strobes in reset", 0, 1);
        check(!sram_dq_oe, "R1", "drive in reset", sram_dq_oe, 0);
        check(req_ready && !rd_valid, "R1", "ready/valid in reset", req_ready, 1);
        rst = 0;
        repeat (2) @(negedge clk);
        check(sram_cs_n && sram_we_n && sram_oe_n && !sram_dq_oe, "R1", "idle after reset", 0, 1);
        // Boundary addresses and extreme patterns, back-to-back writes.
        issue(1, 15'h0000, 8'h00);
        issue(1, 15'h7FFF, 8'hFF);
        issue(1, 15'h1234, 8'hA5);
        // Reads after writes and after reads.
        issue(0, 15'h7FFF, 8'h00);
        issue(0, 15'h0000, 8'h00);
        issue(0, 15'h1234, 8'h00);
        // R6: read then write to the same word, then read back.
        issue(1, 15'h1234, 8'h3C);
        issue(0, 15'h1234, 8'h00);
        // Alternating pattern across several words.
        for (int i = 0; i < 8; i++) begin
            issue(1, 15'(i * 911 + 5), 8'(8'h11 * i + 8'h0F));
            issue(0, 15'(i * 911 + 5), 8'h00);
        end
        // R2: no request, nothing moves.
        repeat (RD + 10) @(negedge clk);
        check(exp_q.size() == 0, "R3", "all reads returned", exp_q.size(), 0);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            check(sram_cs_n && req_ready && !sram_dq_oe, "R2", "idle without request", sram_cs_n, 1);
        end
        summary();
        $finish;
    end
endmodule